// File: doc/BRIEF.md
# Single-Cycle Six-Instruction CPU Datapath

This block is a 32-bit processor datapath that completes one instruction in every clock cycle. In that single cycle it fetches the word addressed by the program counter, splits it into fields, reads two source registers, computes with the ALU, optionally reads or writes the data memory, and writes the result back to the register file. Six operations are recognised: register add and subtract, OR with a zero-extended immediate, word load, word store, and branch-on-equal. Any other encoding retires as a no-op.

The instruction memory is internal. It is filled through a write port, normally while reset is held. The data memory is also internal, and reset clears it. Two combinational inspection ports return one register and one data-memory word, which lets a test environment observe architectural state. Control decoding sits in its own module, which drives a control record into the datapath.

Top module: `cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register and every data-memory word becomes 0. No instruction has any effect during reset.
- R2: Opcode 0x00 with funct 0x21 writes rs+rt into register rd. Opcode 0x00 with funct 0x23 writes rs-rt into register rd. Both are modulo 2^32. Fields: op[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0].
- R3: Opcode 0x0D writes rs OR {16'h0, imm[15:0]} into register rt.
- R4: Opcode 0x23 loads into rt the data word at address rs + sign-extended imm16. The word index is address bits [DAW+1:2]. The other address bits are ignored.
- R5: Opcode 0x2B stores rt to the data word at rs + sign-extended imm16, using the same indexing as R4. It writes no register.
- R6: Opcode 0x04 with rs equal to rt sets PC to PC+4+(sign-extended imm16 shifted left by 2). With rs not equal to rt, the PC becomes PC+4.
- R7: Every instruction that is not a taken branch advances the PC by 4. The instruction executed is the word at index PC[IAW+1:2].
- R8: Register 0 always reads 0, and writes to it are dropped.
- R9: Any other opcode, and opcode 0x00 with any funct other than 0x21 or 0x23, writes no register and no memory and advances the PC by 4.
- R10: An instruction whose destination is also one of its sources reads the value held before that instruction.
- R11: When `imem_we` is high at a rising edge, `imem_wdata` is stored at word `imem_waddr`. `dbg_reg_data` and `dbg_mem_data` show the selected register and data word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | IAW | Instruction word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter (byte address) |
| dbg_reg_sel | input | 5 | Register number to inspect |
| dbg_reg_data | output | 32 | Value of the selected register |
| dbg_mem_sel | input | DAW | Data memory word index to inspect |
| dbg_mem_data | output | 32 | Value of the selected data word |

## Verification
Register read and register write-back fall in the same cycle whenever an instruction names its destination as one of its sources. The design must then use the old source value and commit the new one at the edge. The random programs draw every register field from r0..r7, so collisions of this kind happen often. A directed `addu r7,r7,r7` doubles a known value. After every cycle, the bench compares the PC and a sampled register against a reference model that reads all sources before it writes. At the end of each program, it compares the whole register file and the whole data memory.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int NREG   = 1 << REG_AW;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADDU  = 6'h21;
    localparam logic [5:0] FN_SUBU  = 6'h23;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic [5:0]        op;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } instr_t;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    b_imm;
        logic    imm_zext;
        logic    mem_we;
        logic    mem_to_reg;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [15:0] imm16(input instr_t i);
        return {i.rd, i.shamt, i.funct};
    endfunction

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext16(input logic [15:0] v);
        return {{(XLEN-16){1'b0}}, v};
    endfunction

    function automatic logic [XLEN-1:0] branch_disp(input logic [15:0] v);
        return {sext16(v)[XLEN-3:0], 2'b00};
    endfunction

endpackage

// File: rtl/cpu_decoder.sv
module cpu_decoder
    import cpu_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (op)
            OP_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                if (funct == FN_ADDU) begin
                    ctrl.reg_we = 1'b1;
                end else if (funct == FN_SUBU) begin
                    ctrl.reg_we = 1'b1;
                    ctrl.alu_op = ALU_SUB;
                end
            end
            OP_ORI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_imm    = 1'b1;
                ctrl.imm_zext = 1'b1;
                ctrl.alu_op   = ALU_OR;
            end
            OP_LW: begin
                ctrl.reg_we     = 1'b1;
                ctrl.b_imm      = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OP_SW: begin
                ctrl.b_imm  = 1'b1;
                ctrl.mem_we = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import cpu_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [REG_AW-1:0]                waddr,
    input  logic [XLEN-1:0]                  wdata,
    input  logic [NRD-1:0][REG_AW-1:0]       raddr,
    output logic [NRD-1:0][XLEN-1:0]         rdata
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) regs[k] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
    end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              imem_we,
    input  logic [IAW-1:0]    imem_waddr,
    input  logic [31:0]       imem_wdata,
    output logic [31:0]       pc_o,
    input  logic [4:0]        dbg_reg_sel,
    output logic [31:0]       dbg_reg_data,
    input  logic [DAW-1:0]    dbg_mem_sel,
    output logic [31:0]       dbg_mem_data
);
    logic [XLEN-1:0] pc_q, pc_seq, pc_d;
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];
    instr_t          instr;
    ctrl_t           ctrl;
    logic [15:0]     imm;
    logic [XLEN-1:0] imm_ext, alu_b, alu_y, load_data, wb_data;
    logic [XLEN-1:0] rs_data, rt_data;
    logic            alu_zero, dmem_we;
    logic [REG_AW-1:0] wb_addr;
    logic [2:0][REG_AW-1:0] rf_raddr;
    logic [2:0][XLEN-1:0]   rf_rdata;

    // Fetch
    always_ff @(posedge clk) begin
        if (imem_we) imem[imem_waddr] <= imem_wdata;
    end
    assign instr = instr_t'(imem[pc_q[IAW+1:2]]);
    assign imm   = imm16(instr);

    // Decode
    cpu_decoder u_dec (
        .op    (instr.op),
        .funct (instr.funct),
        .ctrl  (ctrl)
    );

    // Register file: ports 0/1 for sources, port 2 for inspection
    assign rf_raddr = {dbg_reg_sel, instr.rt, instr.rs};
    assign wb_addr  = ctrl.dst_rd ? instr.rd : instr.rt;

    cpu_regfile #(.NRD(3)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl.reg_we & ~rst),
        .waddr (wb_addr),
        .wdata (wb_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );
    assign rs_data      = rf_rdata[0];
    assign rt_data      = rf_rdata[1];
    assign dbg_reg_data = rf_rdata[2];

    // Execute
    assign imm_ext = ctrl.imm_zext ? zext16(imm) : sext16(imm);
    assign alu_b   = ctrl.b_imm ? imm_ext : rt_data;

    cpu_alu u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_data),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Memory
    assign dmem_we = ctrl.mem_we & ~rst;
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DMEM_WORDS; k++) dmem[k] <= '0;
        end else if (dmem_we) begin
            dmem[alu_y[DAW+1:2]] <= rt_data;
        end
    end
    assign load_data    = dmem[alu_y[DAW+1:2]];
    assign dbg_mem_data = dmem[dbg_mem_sel];

    // Write-back
    assign wb_data = ctrl.mem_to_reg ? load_data : alu_y;

    // Next PC
    assign pc_seq = pc_q + XLEN'(4);
    assign pc_d   = (ctrl.branch && alu_zero) ? pc_seq + branch_disp(imm) : pc_seq;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end
    assign pc_o = pc_q;
endmodule

// File: rtl/cpu_core_checker.sv
module cpu_core_checker
    import cpu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_q,
    input logic [31:0] instr_w,
    input logic [31:0] rs_data,
    input logic [31:0] rt_data,
    input logic        reg_we,
    input logic        dmem_we
);
    logic [5:0] op;
    logic       beq_taken;
    logic       known_op;
    assign op        = instr_w[31:26];
    assign beq_taken = (op == OP_BEQ) && (rs_data == rt_data);
    assign known_op  = (op == OP_ORI) || (op == OP_LW) || (op == OP_SW) || (op == OP_BEQ) ||
                       ((op == OP_RTYPE) && (instr_w[5:0] == FN_ADDU || instr_w[5:0] == FN_SUBU));

    a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pc_q == 32'd0));

    a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
        !beq_taken |=> (pc_q == $past(pc_q) + 32'd4));

    a_r6_branch_target: assert property (@(posedge clk) disable iff (rst)
        beq_taken |=> (pc_q == $past(pc_q) + 32'd4 +
                       {{14{$past(instr_w[15])}}, $past(instr_w[15:0]), 2'b00}));

    a_r8_zero_reads: assert property (@(posedge clk) disable iff (rst)
        (instr_w[25:21] == 5'd0) |-> (rs_data == 32'd0));

    a_r5_store_only: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (op == OP_SW) && !reg_we);

    a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> !reg_we && !dmem_we);
endmodule

bind cpu_core cpu_core_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc_q    (pc_q),
    .instr_w (instr),
    .rs_data (rs_data),
    .rt_data (rt_data),
    .reg_we  (ctrl.reg_we),
    .dmem_we (dmem_we)
);

// File: tb/cpu_core_bench.sv
module cpu_core_bench;
    localparam int PERIOD = 10;
    localparam int IW  = 64;
    localparam int DW  = 64;
    localparam int IAW = 6;
    localparam int DAW = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           imem_we = 1'b0;
    logic [IAW-1:0] imem_waddr = '0;
    logic [31:0]    imem_wdata = '0;
    logic [31:0]    pc_o;
    logic [4:0]     dbg_reg_sel = '0;
    logic [31:0]    dbg_reg_data;
    logic [DAW-1:0] dbg_mem_sel = '0;
    logic [31:0]    dbg_mem_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] prog   [IW];
    logic [31:0] m_imem [IW];
    logic [31:0] m_mem  [DW];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;

    always #(PERIOD/2) clk = ~clk;

    cpu_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_cpu_core (
        .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
        .imem_wdata(imem_wdata), .pc_o(pc_o), .dbg_reg_sel(dbg_reg_sel),
        .dbg_reg_data(dbg_reg_data), .dbg_mem_sel(dbg_mem_sel), .dbg_mem_data(dbg_mem_data)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] mk_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // Reference model: one instruction, all sources read before any write (R10)
    task automatic model_step();
        logic [31:0] ins, a, b, sx, addr, npc;
        logic [5:0]  op;
        ins  = m_imem[m_pc[IAW+1:2]];
        op   = ins[31:26];
        a    = m_reg[ins[25:21]];
        b    = m_reg[ins[20:16]];
        sx   = {{16{ins[15]}}, ins[15:0]};
        addr = a + sx;
        npc  = m_pc + 32'd4;
        case (op)
            6'h00: begin
                if (ins[5:0] == 6'h21 && ins[15:11] != 0) m_reg[ins[15:11]] = a + b;
                if (ins[5:0] == 6'h23 && ins[15:11] != 0) m_reg[ins[15:11]] = a - b;
            end
            6'h0D: if (ins[20:16] != 0) m_reg[ins[20:16]] = a | {16'h0, ins[15:0]};
            6'h23: if (ins[20:16] != 0) m_reg[ins[20:16]] = m_mem[addr[DAW+1:2]];
            6'h2B: m_mem[addr[DAW+1:2]] = b;
            6'h04: if (a == b) npc = npc + {sx[29:0], 2'b00};
            default: ;
        endcase
        m_pc = npc;
    endtask

    function automatic logic [31:0] rand_instr();
        int k  = $urandom_range(0, 9);
        int rs = $urandom_range(0, 7);
        int rt = $urandom_range(0, 7);
        int rd = $urandom_range(0, 7);
        case (k)
            0, 1: return mk_r(6'h21, rs, rt, rd);
            2:    return mk_r(6'h23, rs, rt, rd);
            3:    return mk_i(6'h0D, rs, rt, 16'($urandom));
            4, 5: return mk_i(6'h23, rs, rt, 16'($urandom_range(0, 255)) - 16'd128);
            6:    return mk_i(6'h2B, rs, rt, 16'($urandom_range(0, 255)) - 16'd128);
            7:    return mk_i(6'h04, rs, rt, 16'($urandom_range(0, 8)) - 16'd4);
            8:    return {6'h3F, 26'($urandom)};
            default: return mk_r(6'h20, rs, rt, rd);
        endcase
    endfunction

    task automatic load_and_reset();
        rst = 1'b1;
        for (int i = 0; i < IW; i++) begin
            @(negedge clk);
            imem_we = 1'b1; imem_waddr = IAW'(i); imem_wdata = prog[i];
            m_imem[i] = prog[i];
        end
        @(negedge clk);
        imem_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "pc in reset", pc_o, 32'd0);
        dbg_reg_sel = 5'($urandom_range(1, 31)); dbg_mem_sel = DAW'($urandom);
        #1;
        check("R1", "reg cleared", dbg_reg_data, 32'd0);
        check("R1", "mem cleared", dbg_mem_data, 32'd0);
        for (int r = 0; r < 32; r++) m_reg[r] = '0;
        for (int m = 0; m < DW; m++) m_mem[m] = '0;
        m_pc = '0;
        rst = 1'b0;
    endtask

    task automatic run(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            @(negedge clk);
            model_step();
            check("R7", "pc per cycle", pc_o, m_pc);
            dbg_reg_sel = 5'($urandom_range(0, 7));
            #1;
            check("R10", "sampled reg", dbg_reg_data, m_reg[dbg_reg_sel]);
        end
    endtask

    task automatic compare_all();
        for (int r = 0; r < 32; r++) begin
            dbg_reg_sel = 5'(r); #1;
            check("R2", $sformatf("reg %0d", r), dbg_reg_data, m_reg[r]);
        end
        for (int m = 0; m < DW; m++) begin
            dbg_mem_sel = DAW'(m); #1;
            check("R5", $sformatf("mem %0d", m), dbg_mem_data, m_mem[m]);
        end
    endtask

    task automatic peek_reg(input string req, input int r, input logic [31:0] exp);
        dbg_reg_sel = 5'(r); #1;
        check(req, $sformatf("r%0d", r), dbg_reg_data, exp);
    endtask

    initial begin
        void'($urandom(32'd2718));
        // Directed program
        for (int i = 0; i < IW; i++) prog[i] = 32'h0;
        prog[0]  = mk_i(6'h0D, 0, 1, 16'h8000);   // ori r1
        prog[1]  = mk_i(6'h0D, 0, 2, 16'h0010);   // ori r2
        prog[2]  = mk_r(6'h21, 1, 2, 3);          // addu r3
        prog[3]  = mk_r(6'h23, 2, 1, 4);          // subu r4 (wraps)
        prog[4]  = mk_i(6'h2B, 2, 4, 16'hFFFC);   // sw r4,-4(r2) -> word 3
        prog[5]  = mk_i(6'h23, 0, 5, 16'h000F);   // lw r5,15(r0) -> word 3
        prog[6]  = mk_r(6'h21, 3, 3, 0);          // addu r0 (dropped)
        prog[7]  = mk_i(6'h0D, 0, 7, 16'h0003);   // ori r7 = 3
        prog[8]  = mk_r(6'h21, 7, 7, 7);          // addu r7,r7,r7 -> 6
        prog[9]  = 32'hFC00_1234;                 // unknown opcode
        prog[10] = mk_r(6'h20, 1, 1, 8);          // unknown funct
        prog[11] = mk_i(6'h04, 5, 4, 16'h0001);   // beq taken, skips 12
        prog[12] = mk_i(6'h0D, 0, 6, 16'hDEAD);
        prog[13] = mk_i(6'h04, 1, 2, 16'h0005);   // beq not taken
        prog[14] = mk_i(6'h04, 0, 0, 16'hFFFF);   // self loop
        load_and_reset();
        run(20);
        peek_reg("R3", 1, 32'h0000_8000);
        peek_reg("R2", 3, 32'h0000_8010);
        peek_reg("R2", 4, 32'hFFFF_8010);
        peek_reg("R4", 5, 32'hFFFF_8010);
        peek_reg("R8", 0, 32'h0);
        peek_reg("R10", 7, 32'd6);
        peek_reg("R9", 8, 32'h0);
        peek_reg("R6", 6, 32'h0);
        dbg_mem_sel = DAW'(3); #1;
        check("R5", "stored word", dbg_mem_data, 32'hFFFF_8010);
        check("R6", "branch loop pc", pc_o, 32'd56);
        compare_all();

        // R11: reload while running is covered by reset loads; random programs
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < IW; i++) prog[i] = rand_instr();
            load_and_reset();
            run(400);
            compare_all();
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule